// File: doc/BRIEF.md
# Codec Configuration Port

This block is a byte-wide configuration register that sits on an ISA-style I/O bus in front of an audio codec. It answers at the lowest four addresses of the codec's I/O window. The four addresses above them belong to the codec itself and are not decoded here. A host write stores the whole byte. The block turns two fields of that byte into a codec DMA channel number and a codec IRQ line number, which are held in registers for the DMA and interrupt logic elsewhere on the chip.

A read does not return the stored byte. It returns a fixed identification pattern, 0x04, with bit 6 of the stored byte merged in. A controller elsewhere can close the port. When its access-enable bit is clear and the operating-mode flag is 0, reads return 0xFF and writes are dropped. The port takes part in decoding only while its window-enable input is high.

Top module: `codec_cfg_port`

## Requirements
- R1: After reset the stored byte is 0x00, so `dma_chan` is 0, `irq_line` is 5 and an open read returns 0x04.
- R2: An open read at any of the four port addresses returns 0x04 with bit 6 replaced by bit 6 of the stored byte. Bit 2 is always 1 and every other bit is 0.
- R3: When `acc_en` is 0 and `mode` is 0, the port is blocked: a read returns 0xFF and a write changes neither the stored byte nor the outputs.
- R4: The port is open whenever `acc_en` is 1 or `mode` is 1, and a write is then accepted.
- R5: An accepted write selects `dma_chan` from write bits 1:0 by the map 0→0, 1→0, 2→1, 3→3.
- R6: An accepted write selects `irq_line` from write bits 5:3 by the map 0→5, 1→7, 2→9, 3→10, 4→11, 5→12, 6→14, 7→15.
- R7: `dma_chan` and `irq_line` change at the clock edge that samples an accepted write, and at no other edge.
- R8: The port matches only addresses `cfg_base` to `cfg_base`+3, with the low two bits of `cfg_base` ignored. At any other address, including `cfg_base`+4 to +7, writes are ignored, `rd_drive` stays low and `rd_data` is 0x00.
- R9: While `win_en` is low the port does not respond at any address: writes are ignored and `rd_drive` stays low.
- R10: `rd_drive` is high exactly when a read hits a matched address, whether the port is open or blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| cfg_base | input | 16 | Base address of the codec window |
| win_en | input | 1 | Window enable |
| acc_en | input | 1 | Access-enable bit from the controller |
| mode | input | 1 | Operating-mode flag |
| rd_data | output | 8 | Read data |
| rd_drive | output | 1 | High when the port supplies read data |
| dma_chan | output | 2 | Decoded codec DMA channel |
| irq_line | output | 4 | Decoded codec IRQ number |

## Verification
A wrong stored byte shows on the DMA and IRQ outputs from the edge that latched it. For bit 6 it also shows on the very next open read. A gating fault that lets a blocked write through moves `dma_chan` or `irq_line` one edge later, and a later open read catches any change to bit 6. An address-decode fault shows at once as `rd_drive` on a foreign address, or as an output change after a write outside the window.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int DMA_W  = 2;
  localparam int IRQ_W  = 4;

  function automatic logic [DMA_W-1:0] dma_lut(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [IRQ_W-1:0] irq_lut(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd5;
      3'd1:    return 4'd7;
      3'd2:    return 4'd9;
      3'd3:    return 4'd10;
      3'd4:    return 4'd11;
      3'd5:    return 4'd12;
      3'd6:    return 4'd14;
      default: return 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
  parameter int ADDR_W = 16,
  parameter int SPAN_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              win_en,
  input  logic              rd,
  input  logic              wr,
  input  logic              acc_en,
  input  logic              mode,
  output logic              rd_hit,
  output logic              wr_ok,
  output logic              blocked
);
  logic match;

  always_comb begin
    match   = win_en && (addr[ADDR_W-1:SPAN_W] == base[ADDR_W-1:SPAN_W]);
    blocked = !acc_en && !mode;
    rd_hit  = match && rd;
    wr_ok   = match && wr && !blocked;
  end
endmodule

// File: rtl/cfg_port_store.sv
module cfg_port_store
  import codec_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [DMA_W-1:0]  dma_q,
  output logic [IRQ_W-1:0]  irq_q
);
  logic [BYTE_W-1:0] cfg_d;
  logic [DMA_W-1:0]  dma_d;
  logic [IRQ_W-1:0]  irq_d;

  always_comb begin
    cfg_d = cfg_q;
    dma_d = dma_q;
    irq_d = irq_q;
    if (wr_ok) begin
      cfg_d = wdata;
      dma_d = dma_lut(wdata[1:0]);
      irq_d = irq_lut(wdata[5:3]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      dma_q <= dma_lut(2'd0);
      irq_q <= irq_lut(3'd0);
    end else if (wr_ok) begin
      cfg_q <= cfg_d;
      dma_q <= dma_d;
      irq_q <= irq_d;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(dma_q) && $stable(irq_q) && $stable(cfg_q));

  // R6
  irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && wdata[5:3] == 3'd6 |=> irq_q == 4'd14);

  // R5
  dma_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && wdata[1:0] == 2'd1 |=> dma_q == 2'd0);
endmodule

// File: rtl/cfg_port_rdmux.sv
module cfg_port_rdmux #(
  parameter int          BYTE_W    = 8,
  parameter logic [7:0]  STATUS_ID = 8'h04,
  parameter logic [7:0]  KEEP_MASK = 8'h40
) (
  input  logic              rd_hit,
  input  logic              blocked,
  input  logic [BYTE_W-1:0] cfg,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] status;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign status[i] = STATUS_ID[i] | (KEEP_MASK[i] & cfg[i]);
  end

  always_comb begin
    if (!rd_hit)      rdata = '0;
    else if (blocked) rdata = '1;
    else              rdata = status;
  end
endmodule

// File: rtl/codec_cfg_port.sv
module codec_cfg_port
  import codec_cfg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              win_en,
  input  logic              acc_en,
  input  logic              mode,
  output logic [7:0]        rd_data,
  output logic              rd_drive,
  output logic [1:0]        dma_chan,
  output logic [3:0]        irq_line
);
  logic              rd_hit, wr_ok, blocked;
  logic [BYTE_W-1:0] cfg_q;

  cfg_port_decode #(.ADDR_W(ADDR_W), .SPAN_W(2)) u_dec (
    .addr(io_addr), .base(cfg_base), .win_en(win_en), .rd(io_rd), .wr(io_wr),
    .acc_en(acc_en), .mode(mode), .rd_hit(rd_hit), .wr_ok(wr_ok), .blocked(blocked)
  );

  cfg_port_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wdata(io_wdata),
    .cfg_q(cfg_q), .dma_q(dma_chan), .irq_q(irq_line)
  );

  cfg_port_rdmux #(.BYTE_W(BYTE_W), .STATUS_ID(8'h04), .KEEP_MASK(8'h40)) u_rd (
    .rd_hit(rd_hit), .blocked(blocked), .cfg(cfg_q), .rdata(rd_data)
  );

  assign rd_drive = rd_hit;

  // R3
  gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && !acc_en && !mode |=> $stable(dma_chan) && $stable(irq_line));

  // R2
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive && (acc_en || mode) |-> rd_data[7] == 1'b0 && rd_data[5:0] == 6'h04);

  // R9
  window_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !rd_drive);

  // R9
  window_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en && io_wr |=> $stable(dma_chan) && $stable(irq_line));
endmodule

// File: tb/codec_cfg_port_bench.sv
module codec_cfg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata;
  logic [15:0] cfg_base;
  logic        win_en, acc_en, mode;
  logic [7:0]  rd_data;
  logic        rd_drive;
  logic [1:0]  dma_chan;
  logic [3:0]  irq_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  codec_cfg_port u_codec_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .cfg_base(cfg_base), .win_en(win_en), .acc_en(acc_en),
    .mode(mode), .rd_data(rd_data), .rd_drive(rd_drive), .dma_chan(dma_chan),
    .irq_line(irq_line)
  );

  // fields: wdata[21:14] dma[13:12] irq[11:8] read[7:0]
  localparam logic [21:0] VEC [8] = '{
    {8'h00, 2'd0, 4'd5,  8'h04},
    {8'h09, 2'd0, 4'd7,  8'h04},
    {8'h12, 2'd1, 4'd9,  8'h04},
    {8'h1B, 2'd3, 4'd10, 8'h04},
    {8'h60, 2'd0, 4'd11, 8'h44},
    {8'h6A, 2'd1, 4'd12, 8'h44},
    {8'hB3, 2'd3, 4'd14, 8'h04},
    {8'hF9, 2'd0, 4'd15, 8'h44}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          output logic [1:0] pre_dma, output logic [3:0] pre_irq);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #5;
    pre_dma = dma_chan; pre_irq = irq_line;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic drv);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #5;
    d = rd_data; drv = rd_drive;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       drv;
    logic [1:0] pd;
    logic [3:0] pi;
    rst_n = 1'b0; io_addr = '0; io_rd = 0; io_wr = 0; io_wdata = '0;
    cfg_base = 16'h0530; win_en = 1; acc_en = 1; mode = 0;
    #35;
    // R1 reset state
    check("R1 dma", {6'd0, dma_chan}, 8'd0);
    check("R1 irq", {4'd0, irq_line}, 8'd5);
    @(negedge clk); rst_n = 1'b1;
    do_read(16'h0530, rd, drv);
    check("R1 read", rd, 8'h04);
    check("R10 drive", {7'd0, drv}, 8'd1);

    // table walk: R2 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      do_write(16'h0530 + 16'(i % 4), VEC[i][21:14], pd, pi);
      if (i > 0) begin
        check("R7 pre-edge dma", {6'd0, pd}, {6'd0, VEC[i-1][13:12]});
        check("R7 pre-edge irq", {4'd0, pi}, {4'd0, VEC[i-1][11:8]});
      end
      check("R5 dma", {6'd0, dma_chan}, {6'd0, VEC[i][13:12]});
      check("R6 irq", {4'd0, irq_line}, {4'd0, VEC[i][11:8]});
      do_read(16'h0530 + 16'((i + 1) % 4), rd, drv);
      check("R2 read", rd, VEC[i][7:0]);
      check("R7 hold dma", {6'd0, dma_chan}, {6'd0, VEC[i][13:12]});
    end

    // R3 blocked access
    do_write(16'h0530, 8'h00, pd, pi);
    acc_en = 0; mode = 0;
    do_write(16'h0531, 8'h52, pd, pi);
    check("R3 dma kept", {6'd0, dma_chan}, 8'd0);
    check("R3 irq kept", {4'd0, irq_line}, 8'd5);
    do_read(16'h0532, rd, drv);
    check("R3 read blocked", rd, 8'hFF);
    check("R10 drive blocked", {7'd0, drv}, 8'd1);
    acc_en = 1;
    do_read(16'h0532, rd, drv);
    check("R3 bit6 kept", rd, 8'h04);

    // R4 mode opens port
    acc_en = 0; mode = 1;
    do_write(16'h0533, 8'h52, pd, pi);
    check("R4 dma", {6'd0, dma_chan}, 8'd1);
    check("R4 irq", {4'd0, irq_line}, 8'd9);
    do_read(16'h0530, rd, drv);
    check("R4 read", rd, 8'h44);

    // R8 codec window and foreign addresses
    do_write(16'h0534, 8'h00, pd, pi);
    check("R8 base+4 write", {4'd0, irq_line}, 8'd9);
    do_read(16'h0534, rd, drv);
    check("R8 base+4 read", rd, 8'h00);
    check("R8 base+4 drive", {7'd0, drv}, 8'd0);
    do_write(16'h052F, 8'h00, pd, pi);
    check("R8 below base", {6'd0, dma_chan}, 8'd1);
    cfg_base = 16'h0E80;
    do_write(16'h0E82, 8'h3B, pd, pi);
    check("R8 moved base irq", {4'd0, irq_line}, 8'd15);
    check("R8 moved base dma", {6'd0, dma_chan}, 8'd3);
    do_read(16'h0530, rd, drv);
    check("R8 old base drive", {7'd0, drv}, 8'd0);

    // R9 window disabled
    win_en = 0;
    do_write(16'h0E80, 8'h00, pd, pi);
    check("R9 write ignored", {4'd0, irq_line}, 8'd15);
    do_read(16'h0E80, rd, drv);
    check("R9 no drive", {7'd0, drv}, 8'd0);
    win_en = 1;

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    #5;
    check("R1 mid reset irq", {4'd0, irq_line}, 8'd5);
    check("R1 mid reset dma", {6'd0, dma_chan}, 8'd0);
    @(negedge clk); rst_n = 1;
    do_read(16'h0E81, rd, drv);
    check("R1 mid reset read", rd, 8'h04);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule